// File: doc/BRIEF.md
# Prioritised Interrupt Request Logic

This block collects three hardware interrupt sources of a small 8-bit controller and decides, at each instruction boundary, whether the CPU must enter an interrupt and which vector it fetches. The sources are a primary external pin, a secondary external pin and a request flag from the timer. Both external pins are active on a falling edge. Each pin passes through a synchroniser, and an edge detector then sets a sticky request. A request stays pending while the CPU's global mask bit is set and is taken once that bit clears.

The secondary pin's request flag and its local mask live in an 8-bit auxiliary register on a simple write/read bus. Software may clear the request flag but cannot set it. The timer and the secondary pin share one vector, so the handler reads the request flags to find the source. The primary pin has its own vector and wins when both are pending. On a take, the block pulses `take_irq` for one cycle and updates `vec_addr`. When the primary source was chosen, it also pulses `ext_ack` and clears the primary latch. The CPU reacts to `take_irq` by stacking its state and setting its global mask. That sequence takes 11 cycles and is handled outside this block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `take_irq` and `ext_ack` are 0, and the auxiliary register reads 0x40: request bit 7 is clear and mask bit 6 is set. Bits 5..0 always read 0.
- R2: A falling edge on `ext_irq_n` latches a primary request. At the next boundary with the global mask clear, the block produces a take with `vec_addr` = 0xFFA and `ext_ack` = 1.
- R3: A take occurs only on the cycle after `insn_end` was 1. A pending request never produces a take without a boundary strobe.
- R4: While `cpu_imask` is 1, no take occurs and pending requests stay latched. They are taken at the first boundary after `cpu_imask` returns to 0.
- R5: When the primary request and a shared-vector request are pending at the same boundary, the primary one is taken first (0xFFA). The shared one follows at a later boundary.
- R6: `tmr_req` = 1 at a boundary with the global mask clear gives a take with `vec_addr` = 0xFFA - 2 = 0xFF8 and `ext_ack` = 0.
- R7: A falling edge on `ext_irq2_n` sets register bit 7. While bit 6 is 1 that request causes no take. With bit 6 at 0 it is taken at vector 0xFF8.
- R8: A register write loads bit 6 from write data bit 6. Write data bit 7 = 0 clears bit 7, and write data bit 7 = 1 leaves bit 7 unchanged.
- R9: The primary latch is cleared by its own take. A following boundary with no other request gives no take.
- R10: A rising edge, or a pin held at a steady level, latches no request.
- R11: `take_irq` lasts one cycle per boundary, and `vec_addr` changes only in a cycle where `take_irq` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq_n | input | 1 | Primary external interrupt pin, falling-edge active |
| ext_irq2_n | input | 1 | Secondary external interrupt pin, falling-edge active |
| tmr_req | input | 1 | Timer request flag, already masked locally by the timer |
| cpu_imask | input | 1 | CPU global interrupt mask bit |
| insn_end | input | 1 | One-cycle strobe at the end of an instruction |
| aux_we | input | 1 | Write strobe for the auxiliary register |
| aux_wdata | input | 8 | Write data for the auxiliary register |
| aux_rdata | output | 8 | Current auxiliary register contents |
| take_irq | output | 1 | One-cycle pulse: enter interrupt processing |
| vec_addr | output | 12 | Vector address of the last interrupt taken |
| ext_ack | output | 1 | One-cycle pulse: primary request taken and its latch cleared |

## Verification
The bench builds the block with a three-stage synchroniser instead of the default two. This shows that edge capture and the request latency follow the stage-count parameter. The 12-bit vector width and the default vector constants are kept, so the expected vectors are 0xFFA and 0xFF8. With these values the bench drives coincident primary and shared requests, mask-held requests and write-zero-only register writes. Each pin edge is given enough cycles to pass the deeper synchroniser before the next boundary strobe.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned AUX_W = 8;
  localparam int unsigned AUX_REQ_BIT = AUX_W - 1;
  localparam int unsigned AUX_MASK_BIT = AUX_W - 2;
  localparam int unsigned NUM_PINS = 2;
  localparam int unsigned PIN_EXT = 0;
  localparam int unsigned PIN_EXT2 = 1;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_EXT    = 2'd1,
    SRC_SHARED = 2'd2
  } irq_src_e;
endpackage

// File: rtl/irq_fall_latch.sv
module irq_fall_latch #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  // Pins idle high, so the chain resets to 1 to avoid a false edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/irq_aux_reg.sv
module irq_aux_reg
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AUX_W-1:0] wdata,
  input  logic             set_req,
  output logic [AUX_W-1:0] rdata,
  output logic             req_q,
  output logic             mask_q
);
  logic unused_wbits;
  assign unused_wbits = ^wdata[AUX_MASK_BIT-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      mask_q <= 1'b1;
    end else begin
      // A fresh edge wins over a same-cycle software clear.
      if (set_req)
        req_q <= 1'b1;
      else if (we)
        req_q <= req_q & wdata[AUX_REQ_BIT];
      if (we)
        mask_q <= wdata[AUX_MASK_BIT];
    end
  end

  always_comb begin
    rdata               = '0;
    rdata[AUX_REQ_BIT]  = req_q;
    rdata[AUX_MASK_BIT] = mask_q;
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_prio_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] EXT_VEC = 12'hFFA,
  parameter logic [ADDR_W-1:0] SHR_VEC = 12'hFF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_fall,
  input  logic              shr_req,
  input  logic              imask,
  input  logic              insn_end,
  output logic              take,
  output logic [ADDR_W-1:0] vec,
  output logic              ack,
  output logic              ext_pend
);
  logic     ext_q;
  irq_src_e grant;

  always_comb begin
    grant = SRC_NONE;
    if (insn_end && !imask) begin
      if (ext_q)        grant = SRC_EXT;
      else if (shr_req) grant = SRC_SHARED;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
      take  <= 1'b0;
      ack   <= 1'b0;
      vec   <= '0;
    end else begin
      if (ext_fall)
        ext_q <= 1'b1;
      else if (grant == SRC_EXT)
        ext_q <= 1'b0;
      take <= (grant != SRC_NONE);
      ack  <= (grant == SRC_EXT);
      if (grant == SRC_EXT)
        vec <= EXT_VEC;
      else if (grant == SRC_SHARED)
        vec <= SHR_VEC;
    end
  end

  assign ext_pend = ext_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] EXT_VEC = 12'hFFA,
  parameter logic [ADDR_W-1:0] SHR_VEC = 12'hFF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_irq_n,
  input  logic              ext_irq2_n,
  input  logic              tmr_req,
  input  logic              cpu_imask,
  input  logic              insn_end,
  input  logic              aux_we,
  input  logic [7:0]        aux_wdata,
  output logic [7:0]        aux_rdata,
  output logic              take_irq,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              ext_ack
);
  logic [NUM_PINS-1:0] pins_n;
  logic [NUM_PINS-1:0] falls;
  logic                int2_req, int2_mask, shr_req, ext_pend, int2_fall;

  assign pins_n[PIN_EXT]  = ext_irq_n;
  assign pins_n[PIN_EXT2] = ext_irq2_n;

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    irq_fall_latch #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin_n(pins_n[g]), .fall(falls[g])
    );
  end

  assign int2_fall = falls[PIN_EXT2];

  irq_aux_reg u_aux (
    .clk(clk), .rst_n(rst_n), .we(aux_we), .wdata(aux_wdata),
    .set_req(int2_fall), .rdata(aux_rdata),
    .req_q(int2_req), .mask_q(int2_mask)
  );

  assign shr_req = (int2_req & ~int2_mask) | tmr_req;

  irq_prio_arb #(.ADDR_W(ADDR_W), .EXT_VEC(EXT_VEC), .SHR_VEC(SHR_VEC)) u_arb (
    .clk(clk), .rst_n(rst_n), .ext_fall(falls[PIN_EXT]), .shr_req(shr_req),
    .imask(cpu_imask), .insn_end(insn_end), .take(take_irq), .vec(vec_addr),
    .ack(ext_ack), .ext_pend(ext_pend)
  );
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] EXT_VEC = 12'hFFA,
  parameter logic [ADDR_W-1:0] SHR_VEC = 12'hFF8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tmr_req,
  input logic              cpu_imask,
  input logic              insn_end,
  input logic [7:0]        aux_rdata,
  input logic              take_irq,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              ext_ack,
  input logic              ext_pend,
  input logic              int2_fall
);
  // R3
  boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> $past(insn_end));

  // R4
  mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> !$past(cpu_imask));

  // R2
  ack_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack |-> (take_irq && vec_addr == EXT_VEC));

  // R5
  ext_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && vec_addr == SHR_VEC) |-> !$past(ext_pend));

  // R7
  shared_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && vec_addr == SHR_VEC) |->
      ($past(tmr_req) || ($past(aux_rdata[7]) && !$past(aux_rdata[6]))));

  // R8
  req_set_by_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux_rdata[7]) |-> $past(int2_fall));

  // R11
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_irq |-> $stable(vec_addr));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .ADDR_W(ADDR_W), .EXT_VEC(EXT_VEC), .SHR_VEC(SHR_VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_req(tmr_req), .cpu_imask(cpu_imask),
  .insn_end(insn_end), .aux_rdata(aux_rdata), .take_irq(take_irq),
  .vec_addr(vec_addr), .ext_ack(ext_ack), .ext_pend(ext_pend),
  .int2_fall(int2_fall)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  localparam int unsigned SYNC = 3;
  localparam int unsigned SETTLE = SYNC + 4;
  localparam logic [11:0] V_EXT = 12'hFFA;
  localparam logic [11:0] V_SHR = 12'hFF8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_irq_n = 1'b1, ext_irq2_n = 1'b1, tmr_req = 1'b0;
  logic cpu_imask = 1'b0, insn_end = 1'b0, aux_we = 1'b0;
  logic [7:0] aux_wdata = 8'h00;
  logic [7:0] aux_rdata;
  logic take_irq, ext_ack;
  logic [11:0] vec_addr;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [11:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  irq_prio_ctrl #(.SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .ext_irq2_n(ext_irq2_n),
    .tmr_req(tmr_req), .cpu_imask(cpu_imask), .insn_end(insn_end),
    .aux_we(aux_we), .aux_wdata(aux_wdata), .aux_rdata(aux_rdata),
    .take_irq(take_irq), .vec_addr(vec_addr), .ext_ack(ext_ack)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: every take is popped from the scoreboard and compared.
  always @(negedge clk) begin
    if (rst_n && take_irq) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3/R4/R9 unexpected take", int'(vec_addr), 0);
      end else begin
        automatic logic [11:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(vec_addr == e, t, int'(vec_addr), int'(e));
        check(ext_ack == (e == V_EXT), {t, " ack"}, int'(ext_ack), int'(e == V_EXT));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Driver: optionally queue an expected vector, then strobe a boundary.
  task automatic boundary(input bit expect_take, input logic [11:0] v, input string tag);
    if (expect_take) begin
      exp_q.push_back(v);
      tag_q.push_back(tag);
    end
    @(negedge clk) insn_end = 1'b1;
    @(negedge clk) insn_end = 1'b0;
    @(negedge clk);
    check(exp_q.size() == 0, {tag, " queue drained"}, exp_q.size(), 0);
  endtask

  task automatic fall_ext();
    @(negedge clk) ext_irq_n = 1'b0;
    idle(SETTLE);
    ext_irq_n = 1'b1;
    idle(SETTLE);
  endtask

  task automatic fall_ext2();
    @(negedge clk) ext_irq2_n = 1'b0;
    idle(SETTLE);
    ext_irq2_n = 1'b1;
    idle(SETTLE);
  endtask

  task automatic aux_write(input logic [7:0] d);
    @(negedge clk) begin aux_we = 1'b1; aux_wdata = d; end
    @(negedge clk) aux_we = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(aux_rdata == 8'h40, "R1 aux reset", aux_rdata, 8'h40);
    check(take_irq == 1'b0 && ext_ack == 1'b0, "R1 outputs idle", {take_irq, ext_ack}, 0);

    // R10: boundary with no edge gives nothing
    boundary(1'b0, '0, "R10 idle boundary");

    // R3: latched request waits for the strobe
    fall_ext();
    idle(5);
    check(take_irq == 1'b0, "R3 no take without boundary", take_irq, 0);
    // R2
    boundary(1'b1, V_EXT, "R2 ext take");
    // R9
    boundary(1'b0, '0, "R9 latch cleared");

    // R4: masked request held, then taken
    cpu_imask = 1'b1;
    fall_ext();
    boundary(1'b0, '0, "R4 masked");
    cpu_imask = 1'b0;
    boundary(1'b1, V_EXT, "R4 taken after unmask");

    // R6: timer
    tmr_req = 1'b1;
    boundary(1'b1, V_SHR, "R6 timer vector");
    tmr_req = 1'b0;

    // R5: both pending, primary first
    tmr_req = 1'b1;
    fall_ext();
    boundary(1'b1, V_EXT, "R5 ext wins");
    boundary(1'b1, V_SHR, "R5 shared next");
    tmr_req = 1'b0;

    // R7: secondary pin with mask set after reset
    fall_ext2();
    check(aux_rdata == 8'hC0, "R7 req bit set", aux_rdata, 8'hC0);
    boundary(1'b0, '0, "R7 masked secondary");
    // R8: writing 1 keeps the request, mask cleared
    aux_write(8'h80);
    check(aux_rdata == 8'h80, "R8 write one no effect", aux_rdata, 8'h80);
    boundary(1'b1, V_SHR, "R7 secondary taken");
    // R8: write zero clears
    aux_write(8'h00);
    check(aux_rdata == 8'h00, "R8 write zero clears", aux_rdata, 8'h00);
    aux_write(8'hBF);
    check(aux_rdata == 8'h00, "R8 cannot set req", aux_rdata, 8'h00);
    aux_write(8'h40);
    check(aux_rdata == 8'h40, "R8 mask writable", aux_rdata, 8'h40);
    boundary(1'b0, '0, "R8 no shared request");

    // R10: held low gives one request, rising edge gives none
    @(negedge clk) ext_irq_n = 1'b0;
    idle(SETTLE);
    boundary(1'b1, V_EXT, "R10 single fall");
    idle(SETTLE);
    boundary(1'b0, '0, "R10 steady low");
    ext_irq_n = 1'b1;
    idle(SETTLE);
    boundary(1'b0, '0, "R10 rising edge");

    // R11: pulse width and vector hold
    tmr_req = 1'b1;
    exp_q.push_back(V_SHR);
    tag_q.push_back("R11 timer take");
    @(negedge clk) insn_end = 1'b1;
    @(negedge clk) begin insn_end = 1'b0; tmr_req = 1'b0; end
    @(negedge clk);
    check(take_irq == 1'b0, "R11 one-cycle pulse", take_irq, 0);
    check(vec_addr == V_SHR, "R11 vector held", vec_addr, V_SHR);

    idle(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule